// File: doc/BRIEF.md
# Power-Up Strap Capture Sequencer

This block controls the startup of pads that do two jobs. For a fixed time after the supply is reported good, the pads are configuration inputs. After that time they drive clock outputs. While the timer runs, the pad drivers stay in high impedance, so the external pull resistors (to ground or to the supply) alone set the level on each pad. When the timer expires, the sequencer stores every pad level in a sticky register and then turns the drivers on.

There are four pads. Bits 0 to 2 are the frequency-select code. Bit 3 selects the rate of the secondary I/O clock. Each pad level passes through a two-flop synchronizer before it is stored. A done flag stays low until the stored values are valid, and downstream clock gating uses it so that no output toggles early. The only thing that clears the stored values is power-good going low, which means a full power cycle.

The sequencer has three states. ST_WINDOW counts the window. ST_CAPTURE lasts one cycle and stores the pad levels. ST_ACTIVE enables the drivers and is held until power is lost. The transitions are:
- WINDOW_EXPIRED, from ST_WINDOW to ST_CAPTURE.
- CAPTURE_DONE, from ST_CAPTURE to ST_ACTIVE.
- POWER_LOSS, from any state back to ST_WINDOW. This transition is asynchronous and is caused by power-good going low.

Top module: `strap_capture_ctrl`

## Requirements
- R1: While `pwr_good` is low, `pad_oe` is all zeros, `outputs_live` is 0 and `strap_q` is all zeros.
- R2: After `pwr_good` rises, `pad_oe` stays all zeros and `outputs_live` stays 0 through the first WINDOW_CYCLES rising clock edges.
- R3: The stored value keeps the pad positions: `strap_q[i]` is the level of `strap_pin[i]`, where 0 means pulled to ground and 1 means pulled to supply. Bits 2:0 are the frequency-select code and bit 3 is the secondary-clock select.
- R4: Pad levels pass through a two-stage synchronizer. The value stored is the pad level at rising edge WINDOW_CYCLES-1. A pad change made after that edge is not stored, and a change made one edge earlier is stored.
- R5: On rising edge WINDOW_CYCLES+1 after `pwr_good` rises, `pad_oe` becomes all ones. On that same edge `strap_q` takes the stored value.
- R6: While the block is active, pad level changes have no effect on `strap_q`.
- R7: If `pwr_good` drops at any point, including partway through the window, the stored values clear and the window restarts from zero when `pwr_good` rises again.
- R8: `aux_sel_24m` equals the stored bit 3. A 1 means the secondary clock runs at 24 MHz and a 0 means it runs at 48 MHz.
- R9: `outputs_live` rises in the same cycle that the drivers are enabled and never before the stored value is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock (14.318 MHz in the default setting) |
| pwr_good | input | 1 | Supply-good, active high. Low is an asynchronous full reset |
| strap_pin | input | NUM_STRAPS | Pad levels read back while the pads are tri-stated |
| strap_q | output | NUM_STRAPS | Sticky stored strap values |
| pad_oe | output | NUM_STRAPS | Per-pad output driver enable |
| outputs_live | output | 1 | Done flag: straps stored and clocks allowed to run |
| aux_sel_24m | output | 1 | Secondary clock select: 1 for 24 MHz, 0 for 48 MHz |

## Verification
Storing the synchronized pad levels and turning the drivers on happen on the same clock edge, and the test checks that nothing is visible one edge earlier. A second collision is between a pad change and the end of the window. The bench changes the pads right after edge WINDOW_CYCLES-1 and expects the old value to be stored. It then changes them one edge earlier and expects the new value. A power drop partway through the window, followed by a normal power-up, shows that the timer restarts and the stored values clear.

// File: rtl/strap_pkg.sv
package strap_pkg;
    typedef enum logic [1:0] {
        ST_WINDOW  = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_ACTIVE  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/window_timer.sv
module window_timer #(
    parameter int CYCLES = 28636
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (run && (cnt != LAST)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt == LAST);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST); // R2
endmodule

// File: rtl/strap_sync.sv
module strap_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[0] <= '0;
                    else        pipe[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[s] <= '0;
                    else        pipe[s] <= pipe[s-1];
                end
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/strap_capture_ctrl.sv
module strap_capture_ctrl
    import strap_pkg::*;
#(
    parameter int NUM_STRAPS     = 4,
    parameter int WINDOW_CYCLES  = 28636,
    parameter int SYNC_STAGES    = 2
) (
    input  logic                  clk_ref,
    input  logic                  pwr_good,
    input  logic [NUM_STRAPS-1:0] strap_pin,
    output logic [NUM_STRAPS-1:0] strap_q,
    output logic [NUM_STRAPS-1:0] pad_oe,
    output logic                  outputs_live,
    output logic                  aux_sel_24m
);
    localparam int AUX_BIT = NUM_STRAPS - 1;

    seq_state_t            state, state_nx;
    logic                  win_expired;
    logic [NUM_STRAPS-1:0] pin_sync;

    strap_sync #(.W(NUM_STRAPS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk_ref),
        .rst_n (pwr_good),
        .d     (strap_pin),
        .q     (pin_sync)
    );

    window_timer #(.CYCLES(WINDOW_CYCLES)) u_timer (
        .clk     (clk_ref),
        .rst_n   (pwr_good),
        .run     (state == ST_WINDOW),
        .expired (win_expired)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WINDOW:  if (win_expired) state_nx = ST_CAPTURE;
            ST_CAPTURE: state_nx = ST_ACTIVE;
            ST_ACTIVE:  state_nx = ST_ACTIVE;
            default:    state_nx = ST_WINDOW;
        endcase
    end

    // State register: only power loss returns to the window
    always_ff @(posedge clk_ref or negedge pwr_good) begin
        if (!pwr_good) state <= ST_WINDOW;
        else           state <= state_nx;
    end

    // Sticky strap store, cleared only by power loss
    always_ff @(posedge clk_ref or negedge pwr_good) begin
        if (!pwr_good)                strap_q <= '0;
        else if (state == ST_CAPTURE) strap_q <= pin_sync;
    end

    // Outputs
    always_comb begin
        pad_oe       = '0;
        outputs_live = 1'b0;
        unique case (state)
            ST_WINDOW:  ;
            ST_CAPTURE: ;
            ST_ACTIVE: begin
                pad_oe       = '1;
                outputs_live = 1'b1;
            end
            default: ;
        endcase
    end

    assign aux_sel_24m = strap_q[AUX_BIT];

    AST_CAPTURE_ONE_CYCLE: assert property (@(posedge clk_ref) disable iff (!pwr_good)
        state == ST_CAPTURE |=> state == ST_ACTIVE); // R5
    AST_LIVE_AFTER_CAPTURE: assert property (@(posedge clk_ref) disable iff (!pwr_good)
        $rose(outputs_live) |-> $past(state) == ST_CAPTURE); // R9
    AST_STORE_FROM_SYNC: assert property (@(posedge clk_ref) disable iff (!pwr_good)
        $past(state) == ST_CAPTURE |-> strap_q == $past(pin_sync)); // R4
    AST_STRAP_STICKY: assert property (@(posedge clk_ref) disable iff (!pwr_good)
        (state == ST_ACTIVE && $past(state) == ST_ACTIVE) |-> $stable(strap_q)); // R6
    AST_NO_EARLY_DRIVE: assert property (@(posedge clk_ref) disable iff (!pwr_good)
        !win_expired |-> pad_oe == '0); // R2
endmodule

// File: tb/strap_capture_ctrl_tb.sv
module strap_capture_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 40;
    localparam int NS         = 4;

    logic          clk_ref = 1'b0;
    logic          pwr_good = 1'b0;
    logic [NS-1:0] strap_pin = '0;
    logic [NS-1:0] strap_q;
    logic [NS-1:0] pad_oe;
    logic          outputs_live;
    logic          aux_sel_24m;

    int vectors = 0;
    int miscompares = 0;
    logic [NS-1:0] exp_q [$];

    always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

    strap_capture_ctrl #(.NUM_STRAPS(NS), .WINDOW_CYCLES(WIN), .SYNC_STAGES(2)) u_dut (
        .clk_ref      (clk_ref),
        .pwr_good     (pwr_good),
        .strap_pin    (strap_pin),
        .strap_q      (strap_q),
        .pad_oe       (pad_oe),
        .outputs_live (outputs_live),
        .aux_sel_24m  (aux_sel_24m)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
        end
    endtask

    // Driver: power up with 'pins'; optionally change pins after edge chg_edge
    task automatic power_up(input logic [NS-1:0] pins, input logic [NS-1:0] late_pins,
                            input int chg_edge, input logic [NS-1:0] expv);
        @(negedge clk_ref);
        pwr_good  = 1'b0;
        strap_pin = pins;
        repeat (3) @(negedge clk_ref);
        chk(pad_oe == '0, "R1 pad_oe in reset", 32'(pad_oe), 0);
        chk(outputs_live == 1'b0, "R1 live in reset", 32'(outputs_live), 0);
        chk(strap_q == '0, "R1 strap_q in reset", 32'(strap_q), 0);
        exp_q.push_back(expv);
        pwr_good = 1'b1;
        for (int e = 1; e <= WIN + 1; e++) begin
            @(negedge clk_ref);
            if (e == chg_edge) strap_pin = late_pins;
            if (e == WIN) begin
                chk(pad_oe == '0, "R2 pad_oe at last window edge", 32'(pad_oe), 0);
                chk(outputs_live == 1'b0, "R2 live at last window edge", 32'(outputs_live), 0);
            end
            if (e == WIN + 1) begin
                chk(pad_oe == '1, "R5 pad_oe after capture", 32'(pad_oe), 32'hF);
                chk(outputs_live == 1'b1, "R9 live with drivers", 32'(outputs_live), 1);
            end
        end
        // R6: pad activity while active is ignored
        strap_pin = ~strap_pin;
        repeat (3) @(negedge clk_ref);
        strap_pin = ~strap_pin;
        repeat (2) @(negedge clk_ref);
        chk(strap_q == expv, "R6 strap_q sticky", 32'(strap_q), 32'(expv));
    endtask

    // Monitor: compare stored straps as soon as outputs go live (R3, R4, R8)
    initial begin
        forever begin
            @(posedge outputs_live);
            #1;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected live", 32'(strap_q), 0);
            end else begin
                logic [NS-1:0] e;
                e = exp_q.pop_front();
                chk(strap_q == e, "R3 stored straps", 32'(strap_q), 32'(e));
                chk(aux_sel_24m == e[NS-1], "R8 aux select", 32'(aux_sel_24m), 32'(e[NS-1]));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        chk(1'b0, "watchdog", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        power_up(4'b1010, 4'b1010, 0, 4'b1010);   // R3 pattern A
        power_up(4'b0101, 4'b0101, 0, 4'b0101);   // R3 pattern B, R1 clears previous
        power_up(4'b1111, 4'b1111, 0, 4'b1111);   // R8 24 MHz select
        power_up(4'b0000, 4'b0000, 0, 4'b0000);   // R8 48 MHz select
        // R4: change right after edge WIN-1 is too late
        power_up(4'b0110, 4'b1001, WIN - 1, 4'b0110);
        // R4: change one edge earlier is stored
        power_up(4'b0110, 4'b1001, WIN - 2, 4'b1001);
        // R7: power drop mid-window
        @(negedge clk_ref);
        pwr_good = 1'b0;
        strap_pin = 4'b1100;
        repeat (2) @(negedge clk_ref);
        pwr_good = 1'b1;
        repeat (WIN / 2) @(negedge clk_ref);
        pwr_good = 1'b0;
        #1;
        chk(pad_oe == '0, "R7 pad_oe after drop", 32'(pad_oe), 0);
        chk(strap_q == '0, "R7 strap_q after drop", 32'(strap_q), 0);
        power_up(4'b0011, 4'b0011, 0, 4'b0011);   // R7 full restart timing
        repeat (2) @(negedge clk_ref);
        chk(exp_q.size() == 0, "R9 every expected capture seen", 32'(exp_q.size()), 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule